// File: doc/BRIEF.md
# Chained DMA Channel Sequencer

This block sequences a single DMA channel. Software either programs the channel's control, source and destination registers and starts it directly, or points the list register at a chain of four-word descriptors in memory and lets the channel load them itself. In the chained case the sequencer reads each descriptor, copies it into the channel registers, starts the transfer engine, closes the transfer, writes the updated control word back into the descriptor, and moves on to the next descriptor.

Moving the bytes is left to a transfer engine. Here that engine is a down-counter that runs for the programmed length. A peripheral can end a transfer early with an end-of-frame indication and a status byte. A descriptor whose enable bit is clear marks the end of the chain.

Control word layout, shared by the control register and descriptor word 0: bit 0 enable, bit 1 chained mode, bit 2 loop (descriptor is kept untouched), bit 3 jump (the next descriptor address comes from word 3 rather than from the stride), bit 4 end-of-frame flag, bits 15:8 status, bits 31:16 length. Descriptor words, at increasing byte addresses spaced 4 apart: control, source, destination, next pointer.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the channel is idle. `chan_busy`, `mem_req`, `xfer_start` and `list_done` are low, and `ctl_o` and `lar_o` are zero.
- R2: In idle, a write to the control register (`wr_sel`=0) with bit 0 set and bit 1 clear starts a direct transfer. `xfer_start` is high for exactly one cycle, in the cycle after the write, and `xfer_src`/`xfer_dst` show the registers written through `wr_sel`=1 and `wr_sel`=2.
- R3: A direct transfer of length L (L≥1) with no end-of-frame keeps `chan_busy` high for L+2 cycles: one start cycle, L run cycles and one closing cycle.
- R4: A direct transfer makes no memory access. When it closes, bit 0 of the control word is clear and the channel returns to idle.
- R5: A control write with bits 0 and 1 set starts a chained run. The sequencer reads four words starting at the list register (`wr_sel`=3). Each transfer then starts with the source and destination taken from words 1 and 2.
- R6: On a normal closure in chained mode, the sequencer writes the control word back to the descriptor's word 0. The written word has bit 0 cleared, bit 1 set, bit 4 clear and the other fields unchanged.
- R7: When `periph_eof` is high during a run cycle, the transfer closes after that cycle. Bit 4 of the control word is set and bits 15:8 take `periph_stat`. In chained mode this word is written back.
- R8: A descriptor with bit 2 set is never written: its memory stays unchanged.
- R9: After a descriptor closes, the list register advances by 16 when bit 3 is clear and is loaded from word 3 when bit 3 is set.
- R10: A fetched descriptor with bit 0 clear ends the chain. The channel goes idle without starting a transfer or writing memory, `list_done` pulses for one cycle, and the list register keeps that descriptor's address.
- R11: A control write with bit 0 clear during a run aborts the channel. The next cycle shows it idle with the transfer engine stopped, and no writeback occurs.
- R12: Register writes while the channel is busy are ignored, except for the abort write in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 list |
| wr_data | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (descriptor writeback) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the request cycle |
| xfer_start | output | 1 | One-cycle transfer start |
| xfer_src | output | AW | Current source address |
| xfer_dst | output | AW | Current destination address |
| xfer_len | output | CW | Current transfer length |
| xfer_busy | output | 1 | Transfer engine running |
| periph_eof | input | 1 | Peripheral end-of-frame |
| periph_stat | input | 8 | Peripheral status byte |
| list_done | output | 1 | One-cycle end-of-chain pulse |
| chan_busy | output | 1 | Sequencer not idle |
| ctl_o | output | 32 | Channel control register |
| lar_o | output | AW | Channel list register |

## Verification
The bench builds random chains that mix the loop, jump and end-of-frame flags. It compares every descriptor's memory after the run with a closure computed independently. A design that wrote back loop descriptors, left the enable bit set, or dropped the peripheral status would leave the wrong words in memory. A design that mixed up the stride and the jump pointer would fetch the wrong source addresses and end with the wrong list register.

Directed cases target an empty chain, an early end-of-frame in the first run cycle, and a write to a register during a run followed by an abort. A design that ignored the terminator would start a transfer. A design that let software writes through while busy would change `xfer_src`. A design that did not stop the engine on abort would still show `xfer_busy` after the abort.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
   localparam int unsigned CTL_EN     = 0;
   localparam int unsigned CTL_LINK   = 1;
   localparam int unsigned CTL_LOOP   = 2;
   localparam int unsigned CTL_JUMP   = 3;
   localparam int unsigned CTL_EOF    = 4;
   localparam int unsigned STAT_LO    = 8;
   localparam int unsigned STAT_W     = 8;
   localparam int unsigned LEN_LO     = 16;
   localparam int unsigned LEN_W      = 16;
   localparam int unsigned DESC_WORDS = 4;
   localparam int unsigned DESC_BYTES = DESC_WORDS * 4;

   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_LOAD, ST_RUN, ST_CLOSE, ST_WBACK, ST_ADV
   } seq_state_e;

   typedef enum logic [1:0] {
      SEL_CTL  = 2'd0,
      SEL_SRC  = 2'd1,
      SEL_DST  = 2'd2,
      SEL_LIST = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/dma_chain_xfer.sv
module dma_chain_xfer #(
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          abort,
   input  logic [CW-1:0] len,
   output logic          busy,
   output logic          done
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (abort) begin
         busy_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= (len == '0) ? ONE : len;
      end else if (busy_q) begin
         if (cnt_q == ONE) busy_q <= 1'b0;
         else              cnt_q  <= cnt_q - ONE;
      end
   end

   assign busy = busy_q;
   assign done = busy_q && (cnt_q == ONE);

   // R3: a transfer only starts while the engine is idle
   p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q);

   // R3: the engine counts down by one each running cycle
   p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !start && !abort && cnt_q != ONE) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/dma_chain_close.sv
module dma_chain_close
   import dma_chain_pkg::*;
#(
   parameter int unsigned AW = 16
) (
   input  logic [31:0]       ctl_in,
   input  logic              eof,
   input  logic [STAT_W-1:0] stat,
   input  logic [AW-1:0]     lar,
   input  logic [AW-1:0]     nxt,
   output logic [31:0]       ctl_out,
   output logic [AW-1:0]     lar_out,
   output logic              need_wb
);
   localparam logic [AW-1:0] STRIDE = AW'(DESC_BYTES);

   always_comb begin
      ctl_out          = ctl_in;
      ctl_out[CTL_EN]  = 1'b0;
      ctl_out[CTL_EOF] = eof;
      if (eof) ctl_out[STAT_LO +: STAT_W] = stat;
   end

   assign need_wb = ctl_in[CTL_LINK] && !ctl_in[CTL_LOOP];
   assign lar_out = ctl_in[CTL_JUMP] ? nxt : (lar + STRIDE);
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
   import dma_chain_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [31:0]   wr_data,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   output logic          xfer_start,
   output logic [AW-1:0] xfer_src,
   output logic [AW-1:0] xfer_dst,
   output logic [CW-1:0] xfer_len,
   output logic          xfer_busy,
   input  logic          periph_eof,
   input  logic [7:0]    periph_stat,
   output logic          list_done,
   output logic          chan_busy,
   output logic [31:0]   ctl_o,
   output logic [AW-1:0] lar_o
);
   localparam int unsigned   IW       = $clog2(DESC_WORDS);
   localparam logic [IW-1:0] LAST_IDX = IW'(DESC_WORDS - 1);

   if (AW < 5 || AW > 24) begin : g_bad_aw
      $error("dma_chain_seq: AW must lie in 5..24");
   end
   if (CW < 1 || CW > LEN_W) begin : g_bad_cw
      $error("dma_chain_seq: CW must lie in 1..LEN_W");
   end
   if (STAT_W != 8) begin : g_bad_stat
      $error("dma_chain_seq: status field must be one byte");
   end

   seq_state_e          st_q, st_d;
   logic [31:0]         ctl_q;
   logic [AW-1:0]       src_q, dst_q, lar_q, nxt_q;
   logic [IW-1:0]       idx_q;
   logic                eof_q;
   logic [STAT_W-1:0]   stat_q;
   logic                done_q;

   logic                wr_ctl, sw_abort, x_start, x_abort, x_done;
   logic [31:0]         ctl_closed;
   logic [AW-1:0]       lar_next;
   logic                need_wb;

   // descriptor words captured during fetch; the last word is taken directly
   logic [31:0]         shadow [DESC_WORDS-1];
   for (genvar w = 0; w < DESC_WORDS - 1; w++) begin : g_shadow
      logic [31:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                       word_q <= '0;
         else if (st_q == ST_FETCH && idx_q == IW'(w))     word_q <= mem_rdata;
      end
      assign shadow[w] = word_q;
   end

   logic unused_bits;
   assign unused_bits = ^{shadow[1][31:AW], shadow[2][31:AW], mem_rdata[31:AW]};

   assign wr_ctl   = wr_en && (reg_sel_e'(wr_sel) == SEL_CTL);
   assign sw_abort = (st_q == ST_RUN) && wr_ctl && !wr_data[CTL_EN];
   assign x_start  = (st_q == ST_LOAD) && ctl_q[CTL_EN];
   assign x_abort  = sw_abort || ((st_q == ST_RUN) && periph_eof);

   dma_chain_xfer #(.CW(CW)) u_xfer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (x_start),
      .abort (x_abort),
      .len   (ctl_q[LEN_LO +: CW]),
      .busy  (xfer_busy),
      .done  (x_done)
   );

   dma_chain_close #(.AW(AW)) u_close (
      .ctl_in  (ctl_q),
      .eof     (eof_q),
      .stat    (stat_q),
      .lar     (lar_q),
      .nxt     (nxt_q),
      .ctl_out (ctl_closed),
      .lar_out (lar_next),
      .need_wb (need_wb)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (wr_ctl && wr_data[CTL_EN])
                      st_d = wr_data[CTL_LINK] ? ST_FETCH : ST_LOAD;
         ST_FETCH: if (idx_q == LAST_IDX) st_d = ST_LOAD;
         ST_LOAD:  st_d = ctl_q[CTL_EN] ? ST_RUN : ST_IDLE;
         ST_RUN:   if (sw_abort)                 st_d = ST_IDLE;
                   else if (periph_eof || x_done) st_d = ST_CLOSE;
         ST_CLOSE: if (!ctl_q[CTL_LINK]) st_d = ST_IDLE;
                   else                  st_d = need_wb ? ST_WBACK : ST_ADV;
         ST_WBACK: st_d = ST_ADV;
         ST_ADV:   st_d = ST_FETCH;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ctl_q  <= '0;
         src_q  <= '0;
         dst_q  <= '0;
         lar_q  <= '0;
         nxt_q  <= '0;
         idx_q  <= '0;
         eof_q  <= 1'b0;
         stat_q <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               idx_q <= '0;
               if (wr_en) begin
                  unique case (reg_sel_e'(wr_sel))
                     SEL_CTL:  ctl_q <= wr_data;
                     SEL_SRC:  src_q <= wr_data[AW-1:0];
                     SEL_DST:  dst_q <= wr_data[AW-1:0];
                     SEL_LIST: lar_q <= wr_data[AW-1:0];
                     default:  ;
                  endcase
               end
            end
            ST_FETCH: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == LAST_IDX) begin
                  ctl_q           <= shadow[0];
                  ctl_q[CTL_LINK] <= 1'b1;
                  src_q           <= shadow[1][AW-1:0];
                  dst_q           <= shadow[2][AW-1:0];
                  nxt_q           <= mem_rdata[AW-1:0];
               end
            end
            ST_LOAD:  done_q <= !ctl_q[CTL_EN] && ctl_q[CTL_LINK];
            ST_RUN: begin
               if (sw_abort) begin
                  ctl_q[CTL_EN] <= 1'b0;
               end else if (periph_eof) begin
                  eof_q  <= 1'b1;
                  stat_q <= periph_stat;
               end else if (x_done) begin
                  eof_q  <= 1'b0;
               end
            end
            ST_CLOSE: ctl_q <= ctl_closed;
            ST_ADV: begin
               lar_q <= lar_next;
               idx_q <= '0;
            end
            default: ;
         endcase
      end
   end

   assign mem_req    = (st_q == ST_FETCH) || (st_q == ST_WBACK);
   assign mem_we     = (st_q == ST_WBACK);
   assign mem_addr   = (st_q == ST_WBACK) ? lar_q : (lar_q + AW'({idx_q, 2'b00}));
   assign mem_wdata  = ctl_q;
   assign xfer_start = x_start;
   assign xfer_src   = src_q;
   assign xfer_dst   = dst_q;
   assign xfer_len   = ctl_q[LEN_LO +: CW];
   assign list_done  = done_q;
   assign chan_busy  = (st_q != ST_IDLE);
   assign ctl_o      = ctl_q;
   assign lar_o      = lar_q;

   // R2: the start strobe never lasts two cycles
   p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start);

   // R4: memory is only touched in chained mode
   p_direct_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ctl_q[CTL_LINK]);

   // R5: the fourth fetched word is followed by the load step
   p_fetch_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FETCH && idx_q == LAST_IDX) |=> (st_q == ST_LOAD));

   // R6: a written-back control word always has the enable bit cleared
   p_wb_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !mem_wdata[CTL_EN]);

   // R7: an end-of-frame in a run cycle leads to closure with the flag held
   p_eof_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && periph_eof && !sw_abort) |=> (st_q == ST_CLOSE && eof_q));

   // R8: loop descriptors are never written
   p_loop_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !mem_wdata[CTL_LOOP]);

   // R10: the end-of-chain pulse only appears with the channel idle
   p_list_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      list_done |-> (!chan_busy && !xfer_busy));

   // R11: an abort write stops sequencer and engine in one cycle
   p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sw_abort |=> (!chan_busy && !xfer_busy && !mem_req));
endmodule

// File: tb/dma_chain_seq_tb_top.sv
module dma_chain_seq_tb_top;
   localparam int AW = 16;
   localparam int CW = 16;
   localparam logic [31:0] B_EN = 32'h1, B_LINK = 32'h2, B_LOOP = 32'h4, B_JUMP = 32'h8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = '0;
   logic [31:0]   wr_data = '0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;
   logic          xfer_start, xfer_busy, list_done, chan_busy;
   logic [AW-1:0] xfer_src, xfer_dst, lar_o;
   logic [CW-1:0] xfer_len;
   logic          periph_eof = 1'b0;
   logic [7:0]    periph_stat = '0;
   logic [31:0]   ctl_o;

   logic [31:0] mem [64];
   logic        eof_tab [256];
   logic [7:0]  stat_tab [256];
   logic [AW-1:0] src_tab [256];
   logic        src_on [256];
   int start_cnt = 0, wr_cnt = 0, req_cnt = 0, ld_cnt = 0, badaddr_cnt = 0;
   int checks = 0, errors = 0;
   logic ld_prev = 1'b0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dma_chain_seq #(.AW(AW), .CW(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .xfer_start(xfer_start), .xfer_src(xfer_src),
      .xfer_dst(xfer_dst), .xfer_len(xfer_len), .xfer_busy(xfer_busy),
      .periph_eof(periph_eof), .periph_stat(periph_stat), .list_done(list_done),
      .chan_busy(chan_busy), .ctl_o(ctl_o), .lar_o(lar_o));

   assign mem_rdata = mem[mem_addr[7:2]];

   always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: drives peripheral inputs per transfer, counts events
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req) req_cnt++;
         if (mem_req && mem_we) begin
            wr_cnt++;
            if (mem_addr[3:0] != 4'h0) badaddr_cnt++;
         end
         if (list_done) begin
            ld_cnt++;
            chk(!ld_prev, "R10 list_done pulse width", 32'(ld_prev), 32'd0);
         end
         ld_prev = list_done;
         if (xfer_start) begin
            if (src_on[start_cnt])
               chk(xfer_src == src_tab[start_cnt], "R5 source at start", 32'(xfer_src), 32'(src_tab[start_cnt]));
            periph_eof  = eof_tab[start_cnt];
            periph_stat = stat_tab[start_cnt];
            if (start_cnt < 255) start_cnt++;
         end
      end
   end

   function automatic logic [31:0] closed_word(logic [31:0] c, logic e, logic [7:0] s);
      logic [31:0] r = c;
      r[0] = 1'b0;
      r[4] = e;
      if (e) r[15:8] = s;
      return r;
   endfunction

   task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0;
      while (chan_busy && cyc < 3000) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic run_direct(input int len, input bit eof, input logic [7:0] st);
      logic [AW-1:0] s = AW'($urandom);
      logic [31:0] c = B_EN | (32'(len) << 16) | (32'($urandom & 8'hff) << 8) | ($urandom & 32'h1c);
      int cyc, r0;
      eof_tab[start_cnt] = eof; stat_tab[start_cnt] = st;
      src_tab[start_cnt] = s;   src_on[start_cnt] = 1'b1;
      reg_wr(2'd1, 32'(s));
      reg_wr(2'd2, $urandom);
      r0 = req_cnt;
      reg_wr(2'd0, c);
      chk(xfer_start == 1'b1, "R2 start pulse", 32'(xfer_start), 32'd1);
      wait_idle(cyc);
      chk(cyc == (eof ? 3 : len + 2), eof ? "R7 direct eof length" : "R3 direct length", 32'(cyc), 32'(eof ? 3 : len + 2));
      chk(ctl_o == closed_word(c, eof, st), eof ? "R7 direct closed word" : "R4 direct closed word", ctl_o, closed_word(c, eof, st));
      chk(req_cnt == r0, "R4 no memory access", 32'(req_cnt - r0), 32'd0);
   endtask

   task automatic run_chain(input int n, input bit forced, input int loop_m, input int jump_m, input int eof_m);
      logic [31:0] cw [8];
      logic [31:0] wb [8];
      int slots [8];
      int slot = 1, first = 1, base = start_cnt, w0 = wr_cnt, l0 = ld_cnt, nwb = 0, cyc;
      for (int i = 0; i < 64; i++) mem[i] = $urandom;
      for (int i = 0; i < n; i++) begin
         bit lp = forced ? loop_m[i] : ($urandom % 4 == 0);
         bit jp = forced ? jump_m[i] : $urandom % 2;
         bit ef = forced ? eof_m[i]  : ($urandom % 3 == 0);
         logic [7:0] st = 8'($urandom);
         int len = 1 + $urandom % 6;
         int nxt = jp ? slot + 2 : slot + 1;
         logic [31:0] c = B_EN | ($urandom & B_LINK) | (lp ? B_LOOP : 0) | (jp ? B_JUMP : 0)
                          | ($urandom & 32'h0000ff10) | (32'(len) << 16);
         cw[i] = c;
         mem[slot*4] = c;
         if (jp) mem[slot*4+3] = 32'(nxt * 16);
         src_tab[base+i] = mem[slot*4+1][AW-1:0]; src_on[base+i] = 1'b1;
         eof_tab[base+i] = ef; stat_tab[base+i] = st;
         wb[i] = lp ? c : closed_word(c | B_LINK, ef, st);
         if (!lp) nwb++;
         slots[i] = slot;
         slot = nxt;
      end
      mem[slot*4] = mem[slot*4] & ~B_EN;
      reg_wr(2'd3, 32'(first * 16));
      reg_wr(2'd0, B_EN | B_LINK);
      wait_idle(cyc);
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         if (cw[i][2]) chk(mem[slots[i]*4] == wb[i], "R8 loop descriptor untouched", mem[slots[i]*4], wb[i]);
         else if (wb[i][4]) chk(mem[slots[i]*4] == wb[i], "R7 eof writeback", mem[slots[i]*4], wb[i]);
         else chk(mem[slots[i]*4] == wb[i], "R6 normal writeback", mem[slots[i]*4], wb[i]);
      end
      chk(wr_cnt - w0 == nwb, "R8 writeback count", 32'(wr_cnt - w0), 32'(nwb));
      chk(32'(lar_o) == 32'(slot * 16), "R9 list register at end", 32'(lar_o), 32'(slot * 16));
      chk(start_cnt - base == n, "R5 transfers started", 32'(start_cnt - base), 32'(n));
      chk(ld_cnt - l0 == 1, "R10 one list_done", 32'(ld_cnt - l0), 32'd1);
   endtask

   initial begin
      int cyc, w0, s0, l0;
      logic [AW-1:0] keep;
      void'($urandom(32'd2024));
      for (int i = 0; i < 256; i++) begin
         eof_tab[i] = 1'b0; stat_tab[i] = '0; src_tab[i] = '0; src_on[i] = 1'b0;
      end
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      chk(!chan_busy && !mem_req && !xfer_start && !list_done, "R1 reset outputs",
          {28'd0, chan_busy, mem_req, xfer_start, list_done}, 32'd0);
      chk(ctl_o == 32'd0 && lar_o == '0, "R1 reset registers", ctl_o | 32'(lar_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      run_direct(3, 1'b0, 8'h00);
      run_direct(1, 1'b0, 8'h00);
      run_direct(4, 1'b1, 8'hA5);
      for (int k = 0; k < 8; k++) run_direct(1 + $urandom % 8, $urandom % 2, 8'($urandom));

      // R12 and R11: write during a run is ignored, then abort
      reg_wr(2'd1, 32'h1234);
      reg_wr(2'd0, B_EN | (32'd40 << 16));
      repeat (4) @(negedge clk);
      keep = xfer_src;
      reg_wr(2'd1, 32'h5678);
      chk(xfer_src == keep, "R12 write ignored while busy", 32'(xfer_src), 32'(keep));
      reg_wr(2'd0, B_EN | (32'd2 << 16));
      chk(chan_busy && xfer_len == 16'd40, "R12 control write ignored", 32'(xfer_len), 32'd40);
      w0 = wr_cnt;
      reg_wr(2'd0, 32'd0);
      chk(!chan_busy && !xfer_busy, "R11 abort stops channel", {30'd0, chan_busy, xfer_busy}, 32'd0);
      chk(!ctl_o[0], "R11 enable cleared", ctl_o, 32'd0);
      chk(wr_cnt == w0, "R11 no writeback", 32'(wr_cnt - w0), 32'd0);
      wr_data = '0;

      // R10: empty chain
      for (int i = 0; i < 64; i++) mem[i] = '0;
      mem[8] = B_LINK | (32'd3 << 16);
      s0 = start_cnt; w0 = wr_cnt; l0 = ld_cnt;
      reg_wr(2'd3, 32'h20);
      reg_wr(2'd0, B_EN | B_LINK);
      wait_idle(cyc);
      @(negedge clk);
      chk(start_cnt == s0 && wr_cnt == w0, "R10 empty chain quiet", 32'(start_cnt - s0 + wr_cnt - w0), 32'd0);
      chk(ld_cnt - l0 == 1, "R10 list_done on empty chain", 32'(ld_cnt - l0), 32'd1);
      chk(lar_o == 16'h20, "R10 list register kept", 32'(lar_o), 32'h20);

      // directed chains: loop+jump then eof, and jump-only
      run_chain(2, 1'b1, 32'b01, 32'b01, 32'b10);
      run_chain(3, 1'b1, 32'b000, 32'b111, 32'b000);
      run_chain(3, 1'b1, 32'b100, 32'b000, 32'b001);
      for (int k = 0; k < 14; k++) run_chain(1 + $urandom % 5, 1'b0, 0, 0, 0);

      chk(badaddr_cnt == 0, "R6 writeback aligned to word 0", 32'(badaddr_cnt), 32'd0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule